// File: doc/BRIEF.md
# Translation Unit Control Register Write Decoder

This block is the write side of the memory-mapped register file that controls an I/O address translation unit. Software writes with 4-byte or 8-byte accesses. The block decodes the offset and updates the register it selects. It also produces the side effects that the rest of the translation unit depends on:
- a derived log2 size for each queue;
- an acknowledge copy of the main control word;
- a sticky two-level stream table indication;
- a toggle mask for global error acknowledgement;
- a one-cycle request that tells the command engine to look at its queue again.

The register window is 64 KB and is mirrored once. Address bit 16 is dropped, so the upper page behaves exactly like the lower page. Each 64-bit register can be written in one 8-byte access or as two independent 4-byte halves. Every access gets a response one cycle later. The response is an error only when the access size is illegal. Writes to offsets that decode to nothing complete with an OK response.

Top module: `iotu_regwrite`

## Requirements
- R1: Address bit 16 takes no part in decoding. A write at offset 0x1_0000 + X has the same effect as a write at X. Any address bit above 16 that is set makes the write decode to nothing.
- R2: Only sizes 4 and 8 (wr_size in bytes) are legal. A write of any other size changes no register, raises no consume request, and receives resp_err = 1.
- R3: These are the 64-bit registers, with their base offsets:
  - global error IRQ address at 0x020;
  - stream table base at 0x028;
  - command queue base at 0x040;
  - event queue base at 0x050;
  - event queue IRQ address at 0x060.

  A 4-byte write at the base offset updates bits 31:0 and leaves bits 63:32 unchanged. A 4-byte write at base + 4 updates bits 63:32 and leaves bits 31:0 unchanged.
- R4: An 8-byte write at one of the R3 base offsets replaces all 64 bits. An 8-byte write at any other offset, including base + 4 and the 32-bit registers, changes nothing and returns OK.
- R5: A write that covers the low half of a queue base sets that queue's log2 size (cq_log2 / eq_log2) to data bits 4:0. This applies to a 4-byte write at the base offset and to an 8-byte write. The value is clamped to CQ_MAX_LOG2 (default 19) for the command queue and to EQ_MAX_LOG2 (default 17) for the event queue. A write of the high half leaves the size unchanged.
- R6: A write to control word 0 (offset 0x000) stores the data in ctrl0. It also sets ctrl0_ack to the data with the reserved bits cleared. The reserved bits are given by CTRL0_RSVD, which defaults to all bits above bit 4.
- R7: consume_req is high for exactly the one cycle after a write to control word 0, the command queue producer index (0x048) or the global error acknowledge (0x014). It stays low after every other write.
- R8: A write to the stream table configuration (0x030) stores the word. When its format field (bits 17:16) equals 1, it also latches the split field (bits 10:6) into sid_split and sets two_level_en. Once set, two_level_en stays set until reset.
- R9: resp_valid is high exactly one cycle after each write. A write to an undecoded offset changes nothing and returns resp_err = 0. Offset 0x00C, which is where ctrl0_ack would sit, is one such undecoded offset.
- R10: A write to the global error acknowledge (0x014) stores the new value in gerr_ack. It sets gerr_toggled to the old value XOR the new value. gerr_pending is err_status XOR gerr_ack at all times.
- R11: Reset clears every register to zero, including both queue log2 sizes, sid_split and two_level_en. Reset also clears resp_valid and consume_req.
- R12: These 32-bit registers are stored without side effects:
  - ctrl1 at 0x004 and ctrl2 at 0x008;
  - irq_enable at 0x010;
  - global error IRQ data at 0x018 and attributes at 0x01C;
  - command queue consumer index at 0x04C;
  - event queue producer index at 0x058 and consumer index at 0x05C;
  - event queue IRQ data at 0x068 and attributes at 0x06C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write access strobe, one cycle per access |
| wr_addr | input | ADDR_W (17) | Byte offset into the register window |
| wr_size | input | 4 | Access size in bytes |
| wr_data | input | 64 | Write data; a 4-byte access uses bits 31:0 |
| err_status | input | 32 | Current global error flags |
| resp_valid | output | 1 | Response strobe, one cycle after an access |
| resp_err | output | 1 | Error response for an illegal size |
| consume_req | output | 1 | One-cycle request to rescan the command queue |
| ctrl0 | output | 32 | Control word 0 |
| ctrl0_ack | output | 32 | Acknowledge copy of control word 0 |
| ctrl1 | output | 32 | Control word 1 |
| ctrl2 | output | 32 | Control word 2 |
| irq_enable | output | 32 | Interrupt enable word |
| gerr_ack | output | 32 | Global error acknowledge value |
| gerr_toggled | output | 32 | Bits flipped by the last acknowledge write |
| gerr_pending | output | 32 | Global error bits not yet acknowledged |
| gerr_irq_addr | output | 64 | Global error IRQ address |
| gerr_irq_data | output | 32 | Global error IRQ data |
| gerr_irq_attr | output | 32 | Global error IRQ attributes |
| strtab_base | output | 64 | Stream table base |
| strtab_cfg | output | 32 | Stream table configuration |
| sid_split | output | 5 | Stream ID split point |
| two_level_en | output | 1 | Sticky two-level stream table indication |
| cq_base | output | 64 | Command queue base |
| cq_log2 | output | 5 | Command queue log2 size |
| cq_prod | output | 32 | Command queue producer index |
| cq_cons | output | 32 | Command queue consumer index |
| eq_base | output | 64 | Event queue base |
| eq_log2 | output | 5 | Event queue log2 size |
| eq_prod | output | 32 | Event queue producer index |
| eq_cons | output | 32 | Event queue consumer index |
| eq_irq_addr | output | 64 | Event queue IRQ address |
| eq_irq_data | output | 32 | Event queue IRQ data |
| eq_irq_attr | output | 32 | Event queue IRQ attributes |

## Verification
The properties assume that reset is held for several cycles before the first access, and that wr_valid is never high during reset. The sticky two-level bit and the consume request are checked against values sampled in the previous cycle, so that previous cycle must hold a defined, cleared state. The bench raises wr_valid for one cycle at a time from a falling edge, and keeps it low during both reset phases. All addresses it drives fit in 17 bits. Beyond the legal sizes 4 and 8, it drives only the small sizes 1 and 2.

// File: rtl/iotu_reg_pkg.sv
package iotu_reg_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = 32;
    localparam int OFF_W  = 16;
    localparam int LOG2_W = 5;

    // Register offsets within one 64 KB page
    localparam logic [OFF_W-1:0] OFF_CTRL0     = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_CTRL1     = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_CTRL2     = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_IRQ_EN    = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_GERR_ACK  = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_GIRQ_DATA = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_GIRQ_ATTR = 16'h001C;
    localparam logic [OFF_W-1:0] OFF_GIRQ_ADDR = 16'h0020;
    localparam logic [OFF_W-1:0] OFF_STB       = 16'h0028;
    localparam logic [OFF_W-1:0] OFF_STCFG     = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_CQB       = 16'h0040;
    localparam logic [OFF_W-1:0] OFF_CQP       = 16'h0048;
    localparam logic [OFF_W-1:0] OFF_CQC       = 16'h004C;
    localparam logic [OFF_W-1:0] OFF_EQB       = 16'h0050;
    localparam logic [OFF_W-1:0] OFF_EQP       = 16'h0058;
    localparam logic [OFF_W-1:0] OFF_EQC       = 16'h005C;
    localparam logic [OFF_W-1:0] OFF_EIRQ_ADDR = 16'h0060;
    localparam logic [OFF_W-1:0] OFF_EIRQ_DATA = 16'h0068;
    localparam logic [OFF_W-1:0] OFF_EIRQ_ATTR = 16'h006C;

    // Stream table configuration fields
    localparam int FMT_LSB   = 16;
    localparam int FMT_W     = 2;
    localparam int SPLIT_LSB = 6;
    localparam int SPLIT_W   = 5;

    localparam int NUM_WIDE = 5;

    typedef enum logic [4:0] {
        REG_NONE, REG_CTRL0, REG_CTRL1, REG_CTRL2, REG_IRQ_EN, REG_GERR_ACK,
        REG_GIRQ_ADDR, REG_GIRQ_DATA, REG_GIRQ_ATTR, REG_STB, REG_STCFG,
        REG_CQB, REG_CQP, REG_CQC, REG_EQB, REG_EQP, REG_EQC,
        REG_EIRQ_ADDR, REG_EIRQ_DATA, REG_EIRQ_ATTR
    } reg_id_e;

    typedef enum logic [1:0] {
        PART_NONE, PART_LO, PART_HI, PART_ALL
    } part_e;

    typedef struct packed {
        logic    hit;
        reg_id_e id;
        part_e   part;
    } wr_cmd_t;

    // Index of each 64-bit register in the split-register bank
    function automatic reg_id_e wide_id(input int idx);
        case (idx)
            0:       return REG_GIRQ_ADDR;
            1:       return REG_STB;
            2:       return REG_CQB;
            3:       return REG_EQB;
            default: return REG_EIRQ_ADDR;
        endcase
    endfunction

    function automatic logic [LOG2_W-1:0] clamp_log2(input logic [LOG2_W-1:0] v,
                                                     input logic [LOG2_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/iotu_wr_decode.sv
module iotu_wr_decode
    import iotu_reg_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_size,
    output logic              size_ok,
    output wr_cmd_t           cmd
);

    logic [OFF_W-1:0] off;
    logic             in_window;
    logic             is4;
    logic             is8;
    reg_id_e          id32;
    part_e            part32;
    reg_id_e          id64;

    // Bit OFF_W is the page select and is dropped: both pages alias
    assign off       = wr_addr[OFF_W-1:0];
    assign in_window = ((wr_addr >> (OFF_W + 1)) == '0);
    assign is4       = (wr_size == 4'd4);
    assign is8       = (wr_size == 4'd8);
    assign size_ok   = is4 || is8;

    always_comb begin
        id32   = REG_NONE;
        part32 = PART_LO;
        case (off)
            OFF_CTRL0:           id32 = REG_CTRL0;
            OFF_CTRL1:           id32 = REG_CTRL1;
            OFF_CTRL2:           id32 = REG_CTRL2;
            OFF_IRQ_EN:          id32 = REG_IRQ_EN;
            OFF_GERR_ACK:        id32 = REG_GERR_ACK;
            OFF_GIRQ_DATA:       id32 = REG_GIRQ_DATA;
            OFF_GIRQ_ATTR:       id32 = REG_GIRQ_ATTR;
            OFF_GIRQ_ADDR:       id32 = REG_GIRQ_ADDR;
            OFF_GIRQ_ADDR + 4:   begin id32 = REG_GIRQ_ADDR; part32 = PART_HI; end
            OFF_STB:             id32 = REG_STB;
            OFF_STB + 4:         begin id32 = REG_STB; part32 = PART_HI; end
            OFF_STCFG:           id32 = REG_STCFG;
            OFF_CQB:             id32 = REG_CQB;
            OFF_CQB + 4:         begin id32 = REG_CQB; part32 = PART_HI; end
            OFF_CQP:             id32 = REG_CQP;
            OFF_CQC:             id32 = REG_CQC;
            OFF_EQB:             id32 = REG_EQB;
            OFF_EQB + 4:         begin id32 = REG_EQB; part32 = PART_HI; end
            OFF_EQP:             id32 = REG_EQP;
            OFF_EQC:             id32 = REG_EQC;
            OFF_EIRQ_ADDR:       id32 = REG_EIRQ_ADDR;
            OFF_EIRQ_ADDR + 4:   begin id32 = REG_EIRQ_ADDR; part32 = PART_HI; end
            OFF_EIRQ_DATA:       id32 = REG_EIRQ_DATA;
            OFF_EIRQ_ATTR:       id32 = REG_EIRQ_ATTR;
            default:             id32 = REG_NONE;
        endcase
    end

    always_comb begin
        case (off)
            OFF_GIRQ_ADDR: id64 = REG_GIRQ_ADDR;
            OFF_STB:       id64 = REG_STB;
            OFF_CQB:       id64 = REG_CQB;
            OFF_EQB:       id64 = REG_EQB;
            OFF_EIRQ_ADDR: id64 = REG_EIRQ_ADDR;
            default:       id64 = REG_NONE;
        endcase
    end

    always_comb begin
        cmd.hit  = 1'b0;
        cmd.id   = REG_NONE;
        cmd.part = PART_NONE;
        if (wr_valid && in_window) begin
            if (is4 && id32 != REG_NONE) begin
                cmd.hit  = 1'b1;
                cmd.id   = id32;
                cmd.part = part32;
            end else if (is8 && id64 != REG_NONE) begin
                cmd.hit  = 1'b1;
                cmd.id   = id64;
                cmd.part = PART_ALL;
            end
        end
    end

    // R2: a decoded write never comes from an illegal size
    always_comb begin
        p_hit_legal_r2: assert (!cmd.hit || (size_ok && wr_valid));
    end

endmodule

// File: rtl/iotu_split_reg.sv
module iotu_split_reg
    import iotu_reg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  part_e        part,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int H = W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            case (part)
                PART_LO:  q[H-1:0] <= d[H-1:0];
                PART_HI:  q[W-1:H] <= d[H-1:0];
                PART_ALL: q        <= d;
                default:  q        <= q;
            endcase
        end
    end

    p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (we && part == PART_HI) |=> q[H-1:0] == $past(q[H-1:0]));

    p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (we && part == PART_LO) |=> q[W-1:H] == $past(q[W-1:H]));

endmodule

// File: rtl/iotu_qsize.sv
module iotu_qsize
    import iotu_reg_pkg::*;
#(
    parameter int MAX_LOG2 = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LOG2_W-1:0] d,
    output logic [LOG2_W-1:0] q
);

    localparam logic [LOG2_W-1:0] LIM = LOG2_W'(MAX_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= clamp_log2(d, LIM);
        end
    end

    p_size_bound_r5: assert property (@(posedge clk) disable iff (rst)
        q <= LIM);

    p_size_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/iotu_regwrite.sv
module iotu_regwrite
    import iotu_reg_pkg::*;
#(
    parameter int          ADDR_W      = 17,
    parameter int          CQ_MAX_LOG2 = 19,
    parameter int          EQ_MAX_LOG2 = 17,
    parameter logic [31:0] CTRL0_RSVD  = 32'hFFFF_FFE0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_size,
    input  logic [63:0]       wr_data,
    input  logic [31:0]       err_status,
    output logic              resp_valid,
    output logic              resp_err,
    output logic              consume_req,
    output logic [31:0]       ctrl0,
    output logic [31:0]       ctrl0_ack,
    output logic [31:0]       ctrl1,
    output logic [31:0]       ctrl2,
    output logic [31:0]       irq_enable,
    output logic [31:0]       gerr_ack,
    output logic [31:0]       gerr_toggled,
    output logic [31:0]       gerr_pending,
    output logic [63:0]       gerr_irq_addr,
    output logic [31:0]       gerr_irq_data,
    output logic [31:0]       gerr_irq_attr,
    output logic [63:0]       strtab_base,
    output logic [31:0]       strtab_cfg,
    output logic [4:0]        sid_split,
    output logic              two_level_en,
    output logic [63:0]       cq_base,
    output logic [4:0]        cq_log2,
    output logic [31:0]       cq_prod,
    output logic [31:0]       cq_cons,
    output logic [63:0]       eq_base,
    output logic [4:0]        eq_log2,
    output logic [31:0]       eq_prod,
    output logic [31:0]       eq_cons,
    output logic [63:0]       eq_irq_addr,
    output logic [31:0]       eq_irq_data,
    output logic [31:0]       eq_irq_attr
);

    wr_cmd_t            cmd;
    logic               size_ok;
    logic [HALF_W-1:0]  d32;
    logic [DATA_W-1:0]  wide_q [NUM_WIDE];
    logic               cq_lo_we;
    logic               eq_lo_we;

    assign d32 = wr_data[HALF_W-1:0];

    iotu_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .size_ok  (size_ok),
        .cmd      (cmd)
    );

    // Bank of 64-bit registers writable as halves or whole
    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        iotu_split_reg #(.W(DATA_W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .we   (cmd.hit && cmd.id == wide_id(g)),
            .part (cmd.part),
            .d    (wr_data),
            .q    (wide_q[g])
        );
    end

    assign gerr_irq_addr = wide_q[0];
    assign strtab_base   = wide_q[1];
    assign cq_base       = wide_q[2];
    assign eq_base       = wide_q[3];
    assign eq_irq_addr   = wide_q[4];

    // Queue sizes follow writes that cover the low half of the base
    assign cq_lo_we = cmd.hit && cmd.id == REG_CQB && (cmd.part == PART_LO || cmd.part == PART_ALL);
    assign eq_lo_we = cmd.hit && cmd.id == REG_EQB && (cmd.part == PART_LO || cmd.part == PART_ALL);

    iotu_qsize #(.MAX_LOG2(CQ_MAX_LOG2)) u_cq_size (
        .clk (clk), .rst (rst), .we (cq_lo_we),
        .d   (wr_data[LOG2_W-1:0]), .q (cq_log2)
    );

    iotu_qsize #(.MAX_LOG2(EQ_MAX_LOG2)) u_eq_size (
        .clk (clk), .rst (rst), .we (eq_lo_we),
        .d   (wr_data[LOG2_W-1:0]), .q (eq_log2)
    );

    assign gerr_pending = err_status ^ gerr_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid    <= 1'b0;
            resp_err      <= 1'b0;
            consume_req   <= 1'b0;
            ctrl0         <= '0;
            ctrl0_ack     <= '0;
            ctrl1         <= '0;
            ctrl2         <= '0;
            irq_enable    <= '0;
            gerr_ack      <= '0;
            gerr_toggled  <= '0;
            gerr_irq_data <= '0;
            gerr_irq_attr <= '0;
            strtab_cfg    <= '0;
            sid_split     <= '0;
            two_level_en  <= 1'b0;
            cq_prod       <= '0;
            cq_cons       <= '0;
            eq_prod       <= '0;
            eq_cons       <= '0;
            eq_irq_data   <= '0;
            eq_irq_attr   <= '0;
        end else begin
            resp_valid  <= wr_valid;
            resp_err    <= wr_valid && !size_ok;
            consume_req <= 1'b0;
            if (cmd.hit) begin
                case (cmd.id)
                    REG_CTRL0: begin
                        ctrl0       <= d32;
                        ctrl0_ack   <= d32 & ~CTRL0_RSVD;
                        consume_req <= 1'b1;
                    end
                    REG_CTRL1:     ctrl1         <= d32;
                    REG_CTRL2:     ctrl2         <= d32;
                    REG_IRQ_EN:    irq_enable    <= d32;
                    REG_GERR_ACK: begin
                        gerr_toggled <= gerr_ack ^ d32;
                        gerr_ack     <= d32;
                        consume_req  <= 1'b1;
                    end
                    REG_GIRQ_DATA: gerr_irq_data <= d32;
                    REG_GIRQ_ATTR: gerr_irq_attr <= d32;
                    REG_STCFG: begin
                        strtab_cfg <= d32;
                        if (d32[FMT_LSB +: FMT_W] == FMT_W'(1)) begin
                            sid_split    <= d32[SPLIT_LSB +: SPLIT_W];
                            two_level_en <= 1'b1;
                        end
                    end
                    REG_CQP: begin
                        cq_prod     <= d32;
                        consume_req <= 1'b1;
                    end
                    REG_CQC:       cq_cons       <= d32;
                    REG_EQP:       eq_prod       <= d32;
                    REG_EQC:       eq_cons       <= d32;
                    REG_EIRQ_DATA: eq_irq_data   <= d32;
                    REG_EIRQ_ATTR: eq_irq_attr   <= d32;
                    default: ;
                endcase
            end
        end
    end

    p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !(wr_size == 4'd4 || wr_size == 4'd8))
        |=> resp_err && !consume_req && $stable(ctrl0) && $stable(ctrl1) && $stable(cq_prod));

    p_ack_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.id == REG_CTRL0) |=> ctrl0_ack == (ctrl0 & ~CTRL0_RSVD));

    p_consume_source_r7: assert property (@(posedge clk) disable iff (rst)
        consume_req |-> ($past(wr_valid) && !resp_err));

    p_two_level_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $past(two_level_en) |-> two_level_en);

    p_resp_timing_r9: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> resp_valid);

    p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !resp_valid);

    p_toggle_mask_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.id == REG_GERR_ACK) |=> gerr_toggled == ($past(gerr_ack) ^ gerr_ack));

endmodule

// File: tb/iotu_regwrite_test.sv
`timescale 1ns/1ps
module iotu_regwrite_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [3:0]  wr_size = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] err_status = '0;
    logic        resp_valid, resp_err, consume_req;
    logic [31:0] ctrl0, ctrl0_ack, ctrl1, ctrl2, irq_enable;
    logic [31:0] gerr_ack, gerr_toggled, gerr_pending, gerr_irq_data, gerr_irq_attr;
    logic [63:0] gerr_irq_addr, strtab_base, cq_base, eq_base, eq_irq_addr;
    logic [31:0] strtab_cfg, cq_prod, cq_cons, eq_prod, eq_cons, eq_irq_data, eq_irq_attr;
    logic [4:0]  sid_split, cq_log2, eq_log2;
    logic        two_level_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iotu_regwrite uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .err_status(err_status),
        .resp_valid(resp_valid), .resp_err(resp_err), .consume_req(consume_req),
        .ctrl0(ctrl0), .ctrl0_ack(ctrl0_ack), .ctrl1(ctrl1), .ctrl2(ctrl2),
        .irq_enable(irq_enable), .gerr_ack(gerr_ack), .gerr_toggled(gerr_toggled),
        .gerr_pending(gerr_pending), .gerr_irq_addr(gerr_irq_addr),
        .gerr_irq_data(gerr_irq_data), .gerr_irq_attr(gerr_irq_attr),
        .strtab_base(strtab_base), .strtab_cfg(strtab_cfg), .sid_split(sid_split),
        .two_level_en(two_level_en), .cq_base(cq_base), .cq_log2(cq_log2),
        .cq_prod(cq_prod), .cq_cons(cq_cons), .eq_base(eq_base), .eq_log2(eq_log2),
        .eq_prod(eq_prod), .eq_cons(eq_cons), .eq_irq_addr(eq_irq_addr),
        .eq_irq_data(eq_irq_data), .eq_irq_attr(eq_irq_attr)
    );

    typedef struct packed {
        logic [16:0] addr;
        logic [3:0]  size;
        logic [63:0] data;
        logic [4:0]  sel;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{17'h00004, 4'd4, 64'hA5A5_0001,            5'd2,  64'hA5A5_0001,            4'd12}, // R12 ctrl1
        '{17'h10008, 4'd4, 64'h1234,                 5'd3,  64'h1234,                 4'd1},  // R1 alias page
        '{17'h00010, 4'd4, 64'h7,                    5'd4,  64'h7,                    4'd12}, // R12 irq_enable
        '{17'h00020, 4'd4, 64'hDEAD_BEEF,            5'd5,  64'h0000_0000_DEAD_BEEF,  4'd3},  // R3 low half
        '{17'h00024, 4'd4, 64'hCAFE_F00D,            5'd5,  64'hCAFE_F00D_DEAD_BEEF,  4'd3},  // R3 high half
        '{17'h00028, 4'd8, 64'h1111_2222_3333_4444,  5'd8,  64'h1111_2222_3333_4444,  4'd4},  // R4 whole write
        '{17'h0002C, 4'd4, 64'h5555,                 5'd8,  64'h0000_5555_3333_4444,  4'd3},  // R3 high only
        '{17'h00040, 4'd4, 64'h1008,                 5'd11, 64'd8,                    4'd5},  // R5 size 8
        '{17'h00040, 4'd4, 64'h1F,                   5'd11, 64'd19,                   4'd5},  // R5 clamp cmd
        '{17'h00044, 4'd4, 64'hFFFF_FFFF,            5'd10, 64'hFFFF_FFFF_0000_001F,  4'd3},  // R3 cq base
        '{17'h00050, 4'd8, 64'h1012,                 5'd15, 64'd17,                   4'd5},  // R5 clamp evt
        '{17'h00050, 4'd4, 64'h0A,                   5'd15, 64'd10,                   4'd5},  // R5 evt size
        '{17'h00060, 4'd8, 64'h8877_6655_4433_2211,  5'd18, 64'h8877_6655_4433_2211,  4'd4},  // R4 eq irq addr
        '{17'h00068, 4'd4, 64'h99,                   5'd19, 64'h99,                   4'd12}, // R12
        '{17'h0006C, 4'd4, 64'h3,                    5'd20, 64'h3,                    4'd12}, // R12
        '{17'h00018, 4'd4, 64'h42,                   5'd6,  64'h42,                   4'd12}, // R12
        '{17'h0001C, 4'd4, 64'h1,                    5'd7,  64'h1,                    4'd12}, // R12
        '{17'h0004C, 4'd4, 64'h10,                   5'd13, 64'h10,                   4'd12}, // R12 cq_cons
        '{17'h00058, 4'd4, 64'h20,                   5'd16, 64'h20,                   4'd12}, // R12 eq_prod
        '{17'h0005C, 4'd4, 64'h21,                   5'd17, 64'h21,                   4'd12}  // R12 eq_cons
    };

    function automatic logic [63:0] obs(input logic [4:0] k);
        case (k)
            5'd0:  return 64'(ctrl0);
            5'd1:  return 64'(ctrl0_ack);
            5'd2:  return 64'(ctrl1);
            5'd3:  return 64'(ctrl2);
            5'd4:  return 64'(irq_enable);
            5'd5:  return gerr_irq_addr;
            5'd6:  return 64'(gerr_irq_data);
            5'd7:  return 64'(gerr_irq_attr);
            5'd8:  return strtab_base;
            5'd9:  return 64'(strtab_cfg);
            5'd10: return cq_base;
            5'd11: return 64'(cq_log2);
            5'd12: return 64'(cq_prod);
            5'd13: return 64'(cq_cons);
            5'd14: return eq_base;
            5'd15: return 64'(eq_log2);
            5'd16: return 64'(eq_prod);
            5'd17: return 64'(eq_cons);
            5'd18: return eq_irq_addr;
            5'd19: return 64'(eq_irq_data);
            default: return 64'(eq_irq_attr);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; returns at the falling edge after the capturing rising edge
    task automatic wr(input logic [16:0] a, input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 ctrl0",     64'(ctrl0), 0);
        chk("R11 cq_log2",   64'(cq_log2), 0);
        chk("R11 two_level", 64'(two_level_en), 0);
        chk("R11 resp/cons", {62'd0, resp_valid, consume_req}, 0);
        chk("R11 strtab",    strtab_base, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].size, VECS[i].data);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), obs(VECS[i].sel), VECS[i].exp);
            chk($sformatf("R9 resp vec%0d", i), {62'd0, resp_valid, resp_err}, 64'b10);
            chk($sformatf("R7 no consume vec%0d", i), 64'(consume_req), 0);
        end

        // R5 high-half write left the command queue size alone
        chk("R5 size kept", 64'(cq_log2), 19);
        wr(17'h00040, 4'd8, 64'h0000_0001_0000_0005);
        chk("R5 8-byte size", 64'(cq_log2), 5);
        chk("R4 8-byte cq base", cq_base, 64'h0000_0001_0000_0005);

        // R6 and R7 control word 0
        wr(17'h00000, 4'd4, 64'hFFFF_FFFF);
        chk("R6 ctrl0", 64'(ctrl0), 64'hFFFF_FFFF);
        chk("R6 ctrl0_ack", 64'(ctrl0_ack), 64'h1F);
        chk("R7 consume ctrl0", 64'(consume_req), 1);
        @(negedge clk);
        chk("R7 one cycle", 64'(consume_req), 0);
        wr(17'h00048, 4'd4, 64'h5);
        chk("R7 consume prod", 64'(consume_req), 1);
        chk("R7 cq_prod", 64'(cq_prod), 5);

        // R10 acknowledge toggles and pending
        wr(17'h00014, 4'd4, 64'h3);
        chk("R7 consume gack", 64'(consume_req), 1);
        wr(17'h00014, 4'd4, 64'h6);
        chk("R10 gerr_ack", 64'(gerr_ack), 6);
        chk("R10 toggled", 64'(gerr_toggled), 5);
        err_status = 32'h6;
        #1 chk("R10 pending none", 64'(gerr_pending), 0);
        err_status = 32'h7;
        #1 chk("R10 pending one", 64'(gerr_pending), 1);

        // R2 illegal sizes
        wr(17'h00004, 4'd2, 64'h0);
        chk("R2 err size2", {62'd0, resp_valid, resp_err}, 64'b11);
        chk("R2 ctrl1 kept", 64'(ctrl1), 64'hA5A5_0001);
        wr(17'h00048, 4'd1, 64'h77);
        chk("R2 no consume", 64'(consume_req), 0);
        chk("R2 cq_prod kept", 64'(cq_prod), 5);

        // R9 undecoded offsets
        wr(17'h00FF0, 4'd4, 64'h1);
        chk("R9 unknown ok", {62'd0, resp_valid, resp_err}, 64'b10);
        wr(17'h0000C, 4'd4, 64'h0);
        chk("R9 ack offset ignored", 64'(ctrl0_ack), 64'h1F);

        // R4 8-byte writes at non-base offsets
        wr(17'h00004, 4'd8, 64'h0);
        chk("R4 ctrl1 kept", 64'(ctrl1), 64'hA5A5_0001);
        chk("R4 resp ok", 64'(resp_err), 0);
        wr(17'h00024, 4'd8, 64'h0);
        chk("R4 hi 8-byte ignored", gerr_irq_addr, 64'hCAFE_F00D_DEAD_BEEF);

        // R8 stream table configuration
        wr(17'h00030, 4'd4, 64'h0000_01C0);
        chk("R8 fmt0 split", 64'(sid_split), 0);
        chk("R8 fmt0 feature", 64'(two_level_en), 0);
        wr(17'h00030, 4'd4, 64'h0001_0240);
        chk("R8 fmt1 split", 64'(sid_split), 9);
        chk("R8 fmt1 feature", 64'(two_level_en), 1);
        wr(17'h00030, 4'd4, 64'h0000_00C0);
        chk("R8 sticky", 64'(two_level_en), 1);
        chk("R8 split kept", 64'(sid_split), 9);
        chk("R8 cfg stored", 64'(strtab_cfg), 64'hC0);

        // R11 reset after use
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 ctrl0 cleared", 64'(ctrl0), 0);
        chk("R11 feature cleared", 64'(two_level_en), 0);
        chk("R11 eq_log2 cleared", 64'(eq_log2), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule